// File: doc/BRIEF.md
# DDR2 Command Bus Decoder and Protocol Monitor

The block sits on the device side of a DDR2-style command bus and interprets what the controller drives. On each rising clock edge it samples chip select, the row strobe, column strobe and write enable (all active low), the clock enable, a 3-bit bank address and a 14-bit address. It combines these with the clock enable of the previous cycle to produce one decoded command. Commands include bank activation, single and all-bank precharge, reads and writes with or without auto-precharge, mode register writes, refresh, and the entry and exit of self refresh and power down.

Alongside the decode it keeps its own view of the device. For each of the eight banks it holds an open flag and the open row. It also holds the power state (active, self refresh or power down) and a window that protects the burst of length four that a read or write has started. It reports, on registered outputs, the command, the target bank or mode register, the row, the column and the auto-precharge flag. It raises one flag for commands that break bank or power rules and a separate flag for a read or write that would cut into a running burst. Commands that are flagged change no bank or burst state.

The monitor is meant to run alongside a memory model or a controller under test, where the flags point to protocol misuse.

Top module: `ddr2_cmd_mon`

## Requirements
- R1: With both clock enable samples high, chip select high decodes as Deselect whatever the other strobes are. Chip select low with RAS, CAS and WE all high decodes as No Operation.
- R2: With the clock enable high in the previous and current cycle and chip select low, RAS/CAS/WE decode as follows: L,H,H Activate; L,H,L Precharge; H,L,L Write; H,L,H Read; L,L,L Mode Register Set; L,L,H Refresh. The remaining pattern H,H,L decodes as an invalid command and sets cmd_illegal. The command codes on cmd_code are 0 NOP, 1 Deselect, 2 Activate, 3 Precharge one, 4 Precharge all, 5 Write, 6 Write with auto-precharge, 7 Read, 8 Read with auto-precharge, 9 Mode Register Set, 10 Refresh, 11 Self Refresh Entry, 12 Self Refresh Exit, 13 Power Down Entry, 14 Power Down Exit, 15 invalid.
- R3: Precharge with A10 low closes only the bank on BA. Precharge with A10 high is Precharge all (code 4): it closes every bank, ignores BA and reports bank 0.
- R4: For Read and Write, A10 high selects the auto-precharge variant and drives cmd_ap. cmd_col is {A11, A9..A0}. cmd_bank is BA. cmd_row is the row last activated in that bank. For Activate, cmd_row is A13..A0. Fields that a command does not use read zero.
- R5: Mode Register Set reports BA on cmd_bank as the selected mode register.
- R6: Refresh strobes with the clock enable high in the previous cycle and low in the current cycle decode as Self Refresh Entry and set in_self_ref. If any bank is open, the entry is flagged illegal but still taken.
- R7: The clock enable falling while the bus shows Deselect or No Operation decodes as Power Down Entry and sets in_pwr_down. Any other pattern with a falling clock enable decodes as invalid and also enters power down.
- R8: The clock enable rising decodes as Self Refresh Exit when in self refresh, otherwise as Power Down Exit, provided the bus shows Deselect or No Operation; any other pattern decodes as invalid. Either way both power flags clear.
- R9: While the clock enable is low in both cycles, cmd_valid stays low, all command fields read zero and the bus is ignored.
- R10: A Read or Write sampled one cycle after an accepted Read or Write sets burst_viol and changes no state. A Read or Write sampled two cycles after is accepted.
- R11: Activate to an open bank, Read or Write to a closed bank, and Refresh or Mode Register Set while any bank is open set cmd_illegal and change no bank state.
- R12: An accepted Read or Write with auto-precharge sampled at edge t leaves its bank open after edge t and closed after edge t+1.
- R13: Reset (synchronous, active high) closes all banks, clears both power flags, clears the burst window and drives cmd_valid low.
- R14: All outputs are registered and reflect the bus sampled at the most recent rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | 3 | Bank address / mode register select |
| addr | input | 14 | Address A13..A0 |
| cmd_valid | output | 1 | A command was decoded at the last edge |
| cmd_code | output | 4 | Decoded command code (see R2) |
| cmd_bank | output | 3 | Target bank or mode register |
| cmd_row | output | 14 | Row address |
| cmd_col | output | 11 | Column address |
| cmd_ap | output | 1 | Auto-precharge requested |
| cmd_illegal | output | 1 | Command breaks a bank or power rule |
| burst_viol | output | 1 | Read/write cut into a running burst |
| bank_open | output | 8 | Open flag per bank |
| in_self_ref | output | 1 | Device is in self refresh |
| in_pwr_down | output | 1 | Device is in power down |

## Verification
The bench targets the edges between command classes. It places a Read one cycle and then two cycles after another Read: a window off by one would either flag the legal case or miss the interrupt. It issues auto-precharge reads and probes the bank at both edges after them, which catches a close that comes a cycle early or late. It sends Activates, Refreshes and Mode Register Sets against banks that are open, and Reads to closed ones, then reads the row back to show that rejected commands left the stored row alone. Clock enable transitions are driven with both legal and garbage bus patterns. This exposes a decoder that ignores the previous-cycle enable, picks the wrong exit code, or reacts to the bus while held in a low-power state.

// File: rtl/ddr2_mon_pkg.sv
package ddr2_mon_pkg;

    localparam int NUM_BANKS = 8;
    localparam int BA_W      = $clog2(NUM_BANKS);
    localparam int ADDR_W    = 14;
    localparam int COL_W     = 11;
    localparam int CMD_W     = 4;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP   = 4'd0,
        CMD_DESEL = 4'd1,
        CMD_ACT   = 4'd2,
        CMD_PRE   = 4'd3,
        CMD_PREA  = 4'd4,
        CMD_WR    = 4'd5,
        CMD_WRA   = 4'd6,
        CMD_RD    = 4'd7,
        CMD_RDA   = 4'd8,
        CMD_MRS   = 4'd9,
        CMD_REF   = 4'd10,
        CMD_SRE   = 4'd11,
        CMD_SRX   = 4'd12,
        CMD_PDE   = 4'd13,
        CMD_PDX   = 4'd14,
        CMD_BAD   = 4'd15
    } cmd_e;

    typedef enum logic [1:0] {
        PWR_ACTIVE = 2'd0,
        PWR_SELF   = 2'd1,
        PWR_DOWN   = 2'd2
    } pwr_e;

    typedef struct packed {
        cmd_e               cmd;
        logic [BA_W-1:0]    bank;
        logic [ADDR_W-1:0]  row;
        logic [COL_W-1:0]   col;
        logic               ap;
        logic               bad;
    } dec_t;

    function automatic logic is_rw(cmd_e c);
        return (c == CMD_RD) || (c == CMD_RDA) || (c == CMD_WR) || (c == CMD_WRA);
    endfunction

    function automatic logic needs_idle(cmd_e c);
        return (c == CMD_REF) || (c == CMD_MRS) || (c == CMD_SRE);
    endfunction

endpackage

// File: rtl/ddr2_cmd_decode.sv
module ddr2_cmd_decode
    import ddr2_mon_pkg::*;
(
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              cke,
    input  logic              cke_prev,
    input  logic              in_sr,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec,
    output logic              hold
);

    logic [2:0] strobe;
    logic       idle_bus;

    assign strobe   = {ras_n, cas_n, we_n};
    assign idle_bus = cs_n || (strobe == 3'b111);

    always_comb begin
        dec     = '0;
        dec.cmd = CMD_NOP;
        hold    = 1'b0;
        unique case ({cke_prev, cke})
            2'b11: begin
                if (cs_n) begin
                    dec.cmd = CMD_DESEL;
                end else begin
                    unique case (strobe)
                        3'b111: dec.cmd = CMD_NOP;
                        3'b011: begin
                            dec.cmd  = CMD_ACT;
                            dec.bank = ba;
                            dec.row  = addr;
                        end
                        3'b010: begin
                            if (addr[10]) begin
                                dec.cmd = CMD_PREA;
                            end else begin
                                dec.cmd  = CMD_PRE;
                                dec.bank = ba;
                            end
                        end
                        3'b100, 3'b101: begin
                            if (strobe[0]) dec.cmd = addr[10] ? CMD_RDA : CMD_RD;
                            else           dec.cmd = addr[10] ? CMD_WRA : CMD_WR;
                            dec.bank = ba;
                            dec.col  = {addr[11], addr[9:0]};
                            dec.ap   = addr[10];
                        end
                        3'b000: begin
                            dec.cmd  = CMD_MRS;
                            dec.bank = ba;
                        end
                        3'b001: dec.cmd = CMD_REF;
                        default: begin
                            dec.cmd = CMD_BAD;
                            dec.bad = 1'b1;
                        end
                    endcase
                end
            end
            2'b10: begin
                if (!cs_n && strobe == 3'b001) begin
                    dec.cmd = CMD_SRE;
                end else if (idle_bus) begin
                    dec.cmd = CMD_PDE;
                end else begin
                    dec.cmd = CMD_BAD;
                    dec.bad = 1'b1;
                end
            end
            2'b01: begin
                if (idle_bus) begin
                    dec.cmd = in_sr ? CMD_SRX : CMD_PDX;
                end else begin
                    dec.cmd = CMD_BAD;
                    dec.bad = 1'b1;
                end
            end
            default: hold = 1'b1;
        endcase
    end

endmodule

// File: rtl/ddr2_bank_track.sv
module ddr2_bank_track
    import ddr2_mon_pkg::*;
#(
    parameter int NB = NUM_BANKS,
    parameter int RW = ADDR_W,
    localparam int BW = $clog2(NB)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 act_en,
    input  logic [BW-1:0]        act_bank,
    input  logic [RW-1:0]        act_row,
    input  logic                 pre_en,
    input  logic [BW-1:0]        pre_bank,
    input  logic                 pre_all,
    input  logic                 apc_en,
    input  logic [BW-1:0]        apc_bank,
    output logic [NB-1:0]        open_o,
    output logic [NB-1:0][RW-1:0] row_o
);

    for (genvar g = 0; g < NB; g++) begin : g_bank
        logic close_me;
        logic open_me;

        assign close_me = pre_all
                       || (pre_en && pre_bank == BW'(g))
                       || (apc_en && apc_bank == BW'(g));
        assign open_me  = act_en && act_bank == BW'(g);

        always_ff @(posedge clk) begin
            if (rst) begin
                open_o[g] <= 1'b0;
                row_o[g]  <= '0;
            end else begin
                if (close_me) open_o[g] <= 1'b0;
                if (open_me) begin
                    open_o[g] <= 1'b1;
                    row_o[g]  <= act_row;
                end
            end
        end
    end

endmodule

// File: rtl/ddr2_burst_guard.sv
module ddr2_burst_guard #(
    parameter int BURST_CYC = 2,
    parameter int BW        = 3,
    localparam int CW       = (BURST_CYC > 2) ? $clog2(BURST_CYC) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          go_ap,
    input  logic [BW-1:0] go_bank,
    output logic          busy,
    output logic          apc_en,
    output logic [BW-1:0] apc_bank
);

    logic [CW-1:0] remain;
    logic          ap_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain   <= '0;
            ap_pend  <= 1'b0;
            apc_bank <= '0;
        end else if (go) begin
            remain   <= CW'(BURST_CYC - 1);
            ap_pend  <= go_ap;
            apc_bank <= go_bank;
        end else begin
            if (remain != '0) remain <= remain - CW'(1);
            if (remain == CW'(1)) ap_pend <= 1'b0;
        end
    end

    assign busy   = (remain != '0);
    assign apc_en = ap_pend && (remain == CW'(1));

endmodule

// File: rtl/ddr2_cmd_mon.sv
module ddr2_cmd_mon
    import ddr2_mon_pkg::*;
#(
    parameter int BURST_LEN = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic                 cke,
    input  logic [BA_W-1:0]      ba,
    input  logic [ADDR_W-1:0]    addr,
    output logic                 cmd_valid,
    output logic [CMD_W-1:0]     cmd_code,
    output logic [BA_W-1:0]      cmd_bank,
    output logic [ADDR_W-1:0]    cmd_row,
    output logic [COL_W-1:0]     cmd_col,
    output logic                 cmd_ap,
    output logic                 cmd_illegal,
    output logic                 burst_viol,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic                 in_self_ref,
    output logic                 in_pwr_down
);

    localparam int BURST_CYC = BURST_LEN / 2;

    logic                              cke_prev;
    pwr_e                              pstate;
    dec_t                              dec;
    logic                              hold;
    logic [NUM_BANKS-1:0][ADDR_W-1:0]  open_rows;
    logic                              busy;
    logic                              apc_en;
    logic [BA_W-1:0]                   apc_bank;
    logic                              rw_c;
    logic                              tgt_open;
    logic                              ill_c;
    logic                              bviol_c;
    logic                              accept;
    logic [ADDR_W-1:0]                 row_c;

    assign in_self_ref = (pstate == PWR_SELF);
    assign in_pwr_down = (pstate == PWR_DOWN);

    ddr2_cmd_decode u_dec (
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .cke      (cke),
        .cke_prev (cke_prev),
        .in_sr    (in_self_ref),
        .ba       (ba),
        .addr     (addr),
        .dec      (dec),
        .hold     (hold)
    );

    assign rw_c     = is_rw(dec.cmd);
    assign tgt_open = bank_open[dec.bank];
    assign ill_c    = dec.bad
                   || (dec.cmd == CMD_ACT && tgt_open)
                   || (rw_c && !tgt_open)
                   || (needs_idle(dec.cmd) && (|bank_open));
    assign bviol_c  = rw_c && busy;
    assign accept   = !hold && !ill_c && !bviol_c;
    assign row_c    = rw_c ? open_rows[dec.bank] : dec.row;

    ddr2_bank_track #(
        .NB (NUM_BANKS),
        .RW (ADDR_W)
    ) u_banks (
        .clk      (clk),
        .rst      (rst),
        .act_en   (accept && dec.cmd == CMD_ACT),
        .act_bank (dec.bank),
        .act_row  (dec.row),
        .pre_en   (accept && dec.cmd == CMD_PRE),
        .pre_bank (dec.bank),
        .pre_all  (accept && dec.cmd == CMD_PREA),
        .apc_en   (apc_en),
        .apc_bank (apc_bank),
        .open_o   (bank_open),
        .row_o    (open_rows)
    );

    ddr2_burst_guard #(
        .BURST_CYC (BURST_CYC),
        .BW        (BA_W)
    ) u_burst (
        .clk      (clk),
        .rst      (rst),
        .go       (accept && rw_c),
        .go_ap    (dec.ap),
        .go_bank  (dec.bank),
        .busy     (busy),
        .apc_en   (apc_en),
        .apc_bank (apc_bank)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_prev <= 1'b1;
            pstate   <= PWR_ACTIVE;
        end else begin
            cke_prev <= cke;
            if (cke_prev && !cke) begin
                pstate <= (dec.cmd == CMD_SRE) ? PWR_SELF : PWR_DOWN;
            end else if (!cke_prev && cke) begin
                pstate <= PWR_ACTIVE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cmd_valid   <= 1'b0;
            cmd_code    <= CMD_NOP;
            cmd_bank    <= '0;
            cmd_row     <= '0;
            cmd_col     <= '0;
            cmd_ap      <= 1'b0;
            cmd_illegal <= 1'b0;
            burst_viol  <= 1'b0;
        end else begin
            cmd_valid   <= 1'b1;
            cmd_code    <= dec.cmd;
            cmd_bank    <= dec.bank;
            cmd_row     <= row_c;
            cmd_col     <= dec.col;
            cmd_ap      <= dec.ap;
            cmd_illegal <= ill_c;
            burst_viol  <= bviol_c;
        end
    end

endmodule

// File: rtl/ddr2_cmd_mon_chk.sv
module ddr2_cmd_mon_chk
    import ddr2_mon_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 cmd_valid,
    input logic [CMD_W-1:0]     cmd_code,
    input logic [BA_W-1:0]      cmd_bank,
    input logic                 cmd_illegal,
    input logic                 burst_viol,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic                 in_self_ref,
    input logic                 in_pwr_down
);

    logic is_rw_out;
    assign is_rw_out = (cmd_code == CMD_RD) || (cmd_code == CMD_RDA)
                    || (cmd_code == CMD_WR) || (cmd_code == CMD_WRA);

    AST_PWR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({in_self_ref, in_pwr_down})); // R7

    AST_HOLD_ONLY_LOWPWR: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !cmd_valid) |-> (in_self_ref || in_pwr_down)); // R9

    AST_BURST_FLAG_RW: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && burst_viol) |-> is_rw_out); // R10

    AST_PREA_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == CMD_PREA) |-> (bank_open == '0)); // R3

    AST_SRE_SETS_SR: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == CMD_SRE) |-> in_self_ref); // R6

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == CMD_ACT && !cmd_illegal) |-> bank_open[cmd_bank]); // R11

    AST_RW_ON_OPEN: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && is_rw_out && !cmd_illegal && !burst_viol) |-> bank_open[cmd_bank]); // R12

endmodule

bind ddr2_cmd_mon ddr2_cmd_mon_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .cmd_bank    (cmd_bank),
    .cmd_illegal (cmd_illegal),
    .burst_viol  (burst_viol),
    .bank_open   (bank_open),
    .in_self_ref (in_self_ref),
    .in_pwr_down (in_pwr_down)
);

// File: tb/ddr2_cmd_mon_tb.sv
`timescale 1ns/1ps
module ddr2_cmd_mon_tb;
    import ddr2_mon_pkg::*;

    localparam int BURST_CYC = 2;
    localparam logic [3:0] S_NOP = 4'b0111, S_DES = 4'b1000, S_ACT = 4'b0011,
                           S_PRE = 4'b0010, S_WR  = 4'b0100, S_RD  = 4'b0101,
                           S_MRS = 4'b0000, S_REF = 4'b0001, S_RSV = 4'b0110;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
    logic [2:0]  ba = '0;
    logic [13:0] addr = '0;
    logic        cmd_valid, cmd_ap, cmd_illegal, burst_viol, in_self_ref, in_pwr_down;
    logic [3:0]  cmd_code;
    logic [2:0]  cmd_bank;
    logic [13:0] cmd_row;
    logic [10:0] cmd_col;
    logic [7:0]  bank_open;

    always #2.5 clk = ~clk;

    ddr2_cmd_mon u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke(cke), .ba(ba), .addr(addr), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_ap(cmd_ap),
        .cmd_illegal(cmd_illegal), .burst_viol(burst_viol), .bank_open(bank_open),
        .in_self_ref(in_self_ref), .in_pwr_down(in_pwr_down)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference state
    logic [7:0]  m_open;
    logic [13:0] m_row [8];
    bit m_sr, m_pd, m_ckep, m_app;
    int m_cnt, m_apb;
    // expected outputs
    cmd_e x_cmd;
    bit x_valid, x_ap, x_ill, x_bv;
    int x_bank;
    logic [13:0] x_row;
    logic [10:0] x_col;

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_open = '0; m_sr = 0; m_pd = 0; m_ckep = 1; m_app = 0; m_cnt = 0; m_apb = 0;
        for (int i = 0; i < 8; i++) m_row[i] = '0;
    endtask

    task automatic model_step();
        logic [2:0] s;
        bit hold, idle, rw, closeap;
        cmd_e c;
        s = {ras_n, cas_n, we_n};
        idle = cs_n || (s == 3'b111);
        hold = !m_ckep && !cke;
        x_valid = !hold; x_cmd = CMD_NOP; x_bank = 0; x_row = '0; x_col = '0;
        x_ap = 0; x_ill = 0; x_bv = 0; rw = 0;
        if (!hold) begin
            if (m_ckep && cke) begin
                if (cs_n) c = CMD_DESEL;
                else case (s)
                    3'b111: c = CMD_NOP;
                    3'b011: c = CMD_ACT;
                    3'b010: c = addr[10] ? CMD_PREA : CMD_PRE;
                    3'b100: c = addr[10] ? CMD_WRA : CMD_WR;
                    3'b101: c = addr[10] ? CMD_RDA : CMD_RD;
                    3'b000: c = CMD_MRS;
                    3'b001: c = CMD_REF;
                    default: c = CMD_BAD;
                endcase
            end else if (m_ckep) begin
                c = (!cs_n && s == 3'b001) ? CMD_SRE : (idle ? CMD_PDE : CMD_BAD);
            end else begin
                c = idle ? (m_sr ? CMD_SRX : CMD_PDX) : CMD_BAD;
            end
            x_cmd = c;
            rw = (c == CMD_RD) || (c == CMD_RDA) || (c == CMD_WR) || (c == CMD_WRA);
            if (c == CMD_ACT || c == CMD_PRE || c == CMD_MRS || rw) x_bank = int'(ba);
            if (c == CMD_ACT) x_row = addr;
            if (rw) begin
                x_row = m_row[ba];
                x_col = {addr[11], addr[9:0]};
                x_ap = addr[10];
            end
            x_ill = (c == CMD_BAD) || (c == CMD_ACT && m_open[ba]) || (rw && !m_open[ba])
                 || ((c == CMD_REF || c == CMD_MRS || c == CMD_SRE) && m_open != 0);
            x_bv = rw && (m_cnt != 0);
        end
        closeap = m_app && (m_cnt == 1);
        if (m_cnt != 0) m_cnt--;
        if (closeap) begin m_open[m_apb] = 1'b0; m_app = 0; end
        if (!hold && !x_ill && !x_bv) begin
            if (x_cmd == CMD_ACT) begin m_open[ba] = 1'b1; m_row[ba] = addr; end
            if (x_cmd == CMD_PRE) m_open[ba] = 1'b0;
            if (x_cmd == CMD_PREA) m_open = '0;
            if (rw) begin m_cnt = BURST_CYC - 1; m_app = x_ap; m_apb = int'(ba); end
        end
        if (m_ckep && !cke) begin
            if (x_cmd == CMD_SRE) m_sr = 1; else m_pd = 1;
        end else if (!m_ckep && cke) begin
            m_sr = 0; m_pd = 0;
        end
        m_ckep = cke;
    endtask

    task automatic compare_all();
        check("R14 cmd_valid", int'(cmd_valid), int'(x_valid));
        check("R2 cmd_code", int'(cmd_code), int'(x_cmd));
        check("R4 cmd_bank", int'(cmd_bank), x_bank);
        check("R4 cmd_row", int'(cmd_row), int'(x_row));
        check("R4 cmd_col", int'(cmd_col), int'(x_col));
        check("R4 cmd_ap", int'(cmd_ap), int'(x_ap));
        check("R11 cmd_illegal", int'(cmd_illegal), int'(x_ill));
        check("R10 burst_viol", int'(burst_viol), int'(x_bv));
        check("R12 bank_open", int'(bank_open), int'(m_open));
        check("R6 in_self_ref", int'(in_self_ref), int'(m_sr));
        check("R7 in_pwr_down", int'(in_pwr_down), int'(m_pd));
    endtask

    task automatic step(logic [3:0] st, logic k, logic [2:0] b, logic [13:0] a);
        {cs_n, ras_n, cas_n, we_n} = st;
        cke = k; ba = b; addr = a;
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    function automatic logic [13:0] cadr(bit a11, bit ap, logic [9:0] lo);
        return {2'b00, a11, ap, lo};
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d2c_3b4a));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        // R13: reset state
        check("R13 valid after reset", int'(cmd_valid), 0);
        check("R13 banks after reset", int'(bank_open), 0);
        check("R13 power after reset", int'({in_self_ref, in_pwr_down}), 0);

        // R1: deselect with garbage strobes, then NOP
        step(S_DES, 1, 3'd4, 14'h3fff);
        check("R1 deselect", int'(cmd_code), int'(CMD_DESEL));
        step(S_NOP, 1, 3'd0, 14'h0);
        check("R1 nop", int'(cmd_code), int'(CMD_NOP));

        // R14 / R11: activates, then activate to open bank
        step(S_ACT, 1, 3'd2, 14'h1234);
        check("R14 act visible after one edge", int'(cmd_code), int'(CMD_ACT));
        step(S_ACT, 1, 3'd5, 14'h0abc);
        step(S_ACT, 1, 3'd2, 14'h2222);
        check("R11 act to open bank", int'(cmd_illegal), 1);

        // R4 / R10: read, interrupted write, legal write
        step(S_RD, 1, 3'd2, cadr(1, 0, 10'h155));
        check("R4 col", int'(cmd_col), 11'h555);
        check("R4 row kept after rejected act", int'(cmd_row), 14'h1234);
        step(S_WR, 1, 3'd5, cadr(0, 0, 10'h010));
        check("R10 interrupt flagged", int'(burst_viol), 1);
        step(S_WR, 1, 3'd5, cadr(0, 0, 10'h020));
        check("R10 next slot accepted", int'(burst_viol), 0);
        step(S_NOP, 1, 3'd0, 14'h0);

        // R11: refresh / MRS with open banks, read to closed bank
        step(S_REF, 1, 3'd0, 14'h0);
        check("R11 refresh with open bank", int'(cmd_illegal), 1);
        step(S_MRS, 1, 3'd1, 14'h0);
        check("R11 mrs with open bank", int'(cmd_illegal), 1);
        step(S_RD, 1, 3'd7, cadr(0, 0, 10'h0));
        check("R11 read closed bank", int'(cmd_illegal), 1);

        // R12: auto-precharge read
        step(S_RD, 1, 3'd5, cadr(0, 1, 10'h004));
        check("R12 ap flag", int'(cmd_ap), 1);
        check("R12 bank open at t", int'(bank_open[5]), 1);
        step(S_NOP, 1, 3'd0, 14'h0);
        check("R12 bank closed at t+1", int'(bank_open[5]), 0);

        // R3: single and all-bank precharge
        step(S_PRE, 1, 3'd2, 14'h0);
        check("R3 single bank", int'(bank_open), 0);
        step(S_ACT, 1, 3'd0, 14'h0011);
        step(S_ACT, 1, 3'd1, 14'h0022);
        step(S_PRE, 1, 3'd3, 14'h0400);
        check("R3 precharge all", int'(bank_open), 0);
        check("R3 all-bank code", int'(cmd_code), int'(CMD_PREA));

        // R5 / R2: MRS, refresh, reserved pattern
        step(S_MRS, 1, 3'd6, 14'h0123);
        check("R5 mode reg select", int'(cmd_bank), 6);
        step(S_REF, 1, 3'd0, 14'h0);
        check("R2 refresh", int'(cmd_code), int'(CMD_REF));
        step(S_RSV, 1, 3'd0, 14'h0);
        check("R2 reserved pattern", int'(cmd_code), int'(CMD_BAD));

        // R6 / R9 / R8: self refresh
        step(S_REF, 0, 3'd0, 14'h0);
        check("R6 sre", int'(in_self_ref), 1);
        step(S_ACT, 0, 3'd3, 14'h1111);
        check("R9 hold ignores bus", int'(cmd_valid), 0);
        step(S_RD, 0, 3'd3, 14'h0);
        check("R9 hold keeps banks", int'(bank_open), 0);
        step(S_NOP, 1, 3'd0, 14'h0);
        check("R8 self refresh exit", int'(cmd_code), int'(CMD_SRX));

        // R7 / R8: power down with an open bank
        step(S_ACT, 1, 3'd1, 14'h0333);
        step(S_NOP, 0, 3'd0, 14'h0);
        check("R7 pde", int'(in_pwr_down), 1);
        step(S_NOP, 0, 3'd0, 14'h0);
        step(S_DES, 1, 3'd0, 14'h0);
        check("R8 power down exit", int'(cmd_code), int'(CMD_PDX));

        // R6: self refresh entry with a bank open is illegal but taken
        step(S_REF, 0, 3'd0, 14'h0);
        check("R6 sre with open bank", int'(cmd_illegal), 1);
        step(S_ACT, 1, 3'd0, 14'h0);
        check("R8 exit with bad bus", int'(cmd_code), int'(CMD_BAD));
        step(S_WR, 0, 3'd1, 14'h0);
        check("R7 falling cke with bad bus", int'(in_pwr_down), 1);
        step(S_NOP, 1, 3'd0, 14'h0);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] st;
            logic k;
            int r;
            r = int'($urandom % 16);
            case (r)
                0, 1:    st = S_NOP;
                2:       st = S_DES;
                3, 4, 5: st = S_ACT;
                6, 7:    st = S_PRE;
                8, 9:    st = S_RD;
                10, 11:  st = S_WR;
                12:      st = S_MRS;
                13, 14:  st = S_REF;
                default: st = 4'($urandom);
            endcase
            if (m_ckep) k = ($urandom % 24) != 0;
            else        k = ($urandom % 3) == 0;
            step(st, k, 3'($urandom), 14'($urandom));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule